// File: doc/BRIEF.md
# Bit-Serial Multiplierless Dot Product

This block forms the weighted sum of K signed fractional samples against K constant weights without any multiplier. Each sample is an N-bit two's-complement fraction: its top bit has weight -1 and bit n below it has weight 2^-n. All K samples are fed together one bit position per clock, least significant bit first. The K bits of the current position select an entry in a small table. Each entry holds the sum of the weights whose sample bit is set. The table is built at elaboration from the weight parameter.

A scaling accumulator folds each table entry into a running sum that it halves on every ordinary bit. During the final sign-bit slot a timing flag sets the table's top address line. In that slot the table returns the negated subset sum, which is added without halving. A start pulse clears the sum and opens a run. After N bit slots the exact product sum appears on a parallel output with a one-cycle valid strobe. Read as an integer, the output is the sum of weight times sample integer. The low N-1 bits are the fractional part.

Top module: `da_dot_product`

## Requirements
- R1: After reset `result` is 0, `result_valid` is 0 and no run is open.
- R2: A table entry for address {ts, b} equals the sum of the weights W_k with bit k of b set when ts=0, and the negative of that sum when ts=1. Weight k sits in `WEIGHTS[k*CW +: CW]` as a signed value.
- R3: After `start`, the N following cycles carry sample bit positions 0 to N-1 in order, with `bits_in[k]` belonging to sample k. The last of these is the sign-bit slot.
- R4: `result_valid` is high in the cycle right after the sign-bit slot. `result` then equals sum over k of W_k * X_k, where X_k is the N-bit signed integer formed by the fed bits. The value is exact in RW = CW + clog2(K) + N bits.
- R5: With no run open and `start` low, `bits_in` has no effect and `result` keeps its value.
- R6: `start` clears `result` to 0 in the next cycle and lowers `result_valid`. A `start` during an open run abandons that run, which raises no valid.
- R7: When `start` falls in the sign-bit slot, `start` wins. No valid is raised for the old run and a new run begins.
- R8: Extreme operands give exact results, including all samples at the most negative value against the most negative weight.
- R9: `result_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a new run, clears the sum |
| bits_in | input | K | One bit of each sample for the current slot |
| result | output | RW | Signed product sum, N-1 fractional bits |
| result_valid | output | 1 | One-cycle strobe marking a finished result |

## Verification
Two events can land in one cycle: the sign-bit slot of a run that is ending and a `start` for the next run. The bench provokes this by raising `start` exactly in the slot that carries the sign bits. It then expects no valid strobe, a cleared result one cycle later, and a correct answer for the fresh run that follows. The same pairing is also exercised more mildly by back-to-back runs, where `start` meets the valid cycle. An exhaustive sweep of every sample combination for a three-input, four-bit configuration is compared against integer arithmetic.

// File: rtl/da_pkg.sv
package da_pkg;
  // exact width of the product sum
  function automatic int res_width(int cw, int k, int n);
    return cw + $clog2(k) + n;
  endfunction

  // width of one table entry, one spare bit for the negated half
  function automatic int entry_width(int cw, int k);
    return cw + $clog2(k) + 1;
  endfunction
endpackage

// File: rtl/da_bit_sequencer.sv
module da_bit_sequencer #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic sign_slot,
  output logic done_q
);
  localparam int CNTW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(N - 1);

  logic [CNTW-1:0] slot_cnt;

  assign sign_slot = busy && (slot_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      slot_cnt <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= sign_slot && !start;
      if (start) begin
        busy     <= 1'b1;
        slot_cnt <= '0;
      end else if (busy) begin
        if (slot_cnt == LAST) begin
          busy     <= 1'b0;
          slot_cnt <= '0;
        end else begin
          slot_cnt <= slot_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/da_subset_rom.sv
module da_subset_rom import da_pkg::*; #(
  parameter int K  = 4,
  parameter int CW = 8,
  parameter logic [K*CW-1:0] WEIGHTS = '0,
  localparam int TW    = entry_width(CW, K),
  localparam int DEPTH = 2 ** (K + 1)
) (
  input  logic [K:0]           addr,
  output logic signed [TW-1:0] entry
);
  function automatic logic signed [TW-1:0] subset_value(int a);
    logic signed [TW-1:0] acc;
    acc = '0;
    for (int k = 0; k < K; k++) begin
      if (a[k]) acc = acc + TW'($signed(WEIGHTS[k*CW +: CW]));
    end
    if (a[K]) acc = -acc;
    return acc;
  endfunction

  logic signed [TW-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic signed [TW-1:0] VAL = subset_value(i);
    assign table_q[i] = VAL;
  end

  assign entry = table_q[addr];
endmodule

// File: rtl/da_scaling_acc.sv
module da_scaling_acc #(
  parameter int N    = 8,
  parameter int TW   = 11,
  parameter int ACCW = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   step,
  input  logic                   sign_slot,
  input  logic signed [TW-1:0]   entry,
  output logic signed [ACCW-1:0] acc
);
  // entry aligned to the binary point of the running sum
  function automatic logic signed [ACCW-1:0] align(logic signed [TW-1:0] e);
    logic signed [ACCW-1:0] w;
    w = ACCW'(e);
    return w <<< (N - 1);
  endfunction

  // one slot: halve after adding, except in the sign slot
  function automatic logic signed [ACCW-1:0] next_sum(
    logic signed [ACCW-1:0] cur, logic signed [TW-1:0] e, logic is_sign);
    logic signed [ACCW-1:0] s;
    s = cur + align(e);
    return is_sign ? s : (s >>> 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (step)    acc <= next_sum(acc, entry, sign_slot);
  end
endmodule

// File: rtl/da_dot_product.sv
module da_dot_product import da_pkg::*; #(
  parameter int K  = 4,
  parameter int N  = 8,
  parameter int CW = 8,
  parameter logic [K*CW-1:0] WEIGHTS = 32'h80_7F_A6_25,
  localparam int RW = res_width(CW, K, N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [K-1:0]  bits_in,
  output logic [RW-1:0] result,
  output logic          result_valid
);
  localparam int TW   = entry_width(CW, K);
  localparam int ACCW = RW + 1;

  logic                   busy;
  logic                   sign_slot;
  logic signed [TW-1:0]   entry;
  logic signed [ACCW-1:0] acc;
  logic [ACCW-1:RW]       acc_top;

  da_bit_sequencer #(.N(N)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .sign_slot(sign_slot), .done_q(result_valid)
  );

  da_subset_rom #(.K(K), .CW(CW), .WEIGHTS(WEIGHTS)) u_rom (
    .addr({sign_slot, bits_in}), .entry(entry)
  );

  da_scaling_acc #(.N(N), .TW(TW), .ACCW(ACCW)) u_acc (
    .clk(clk), .rst(rst), .clear(start), .step(busy),
    .sign_slot(sign_slot), .entry(entry), .acc(acc)
  );

  // the spare top bit only guards intermediate sums
  assign result  = acc[RW-1:0];
  assign acc_top = acc[ACCW-1:RW];
endmodule

// File: rtl/da_dot_product_checker.sv
module da_dot_product_checker #(
  parameter int RW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          sign_slot,
  input logic          result_valid,
  input logic [RW-1:0] result
);
  assert_valid_after_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (sign_slot && !start) |=> (result_valid && !busy));

  assert_valid_needs_sign_R7: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(sign_slot && !start));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (result == '0 && !result_valid && busy));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
endmodule

bind da_dot_product da_dot_product_checker #(.RW(RW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .sign_slot(sign_slot), .result_valid(result_valid), .result(result)
);

// File: tb/tb_da_dot_product.sv
module tb_da_dot_product;
  localparam int K  = 3;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int RW = CW + $clog2(K) + N;
  // weights: w0=-32, w1=31, w2=-21
  localparam logic [K*CW-1:0] W = {6'h2B, 6'h1F, 6'h20};
  localparam int W0 = -32, W1 = 31, W2 = -21;

  logic clk = 0, rst = 1, start = 0;
  logic [K-1:0]  bits_in = '0;
  logic [RW-1:0] result;
  logic          result_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  da_dot_product #(.K(K), .N(N), .CW(CW), .WEIGHTS(W)) dut (
    .clk(clk), .rst(rst), .start(start), .bits_in(bits_in),
    .result(result), .result_valid(result_valid)
  );

  function automatic int expect_sum(int a, int b, int c);
    return W0 * a + W1 * b + W2 * c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int res_int();
    return int'($signed(result));
  endfunction

  // one bit slot per negedge, LSB first (R3)
  task automatic feed(input int a, input int b, input int c, input int slots);
    logic [N-1:0] va, vb, vc;
    va = N'(a); vb = N'(b); vc = N'(c);
    for (int n = 0; n < slots; n++) begin
      bits_in = {vc[n], vb[n], va[n]};
      @(negedge clk);
    end
    bits_in = '0;
  endtask

  task automatic open_run();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic full_op(input int a, input int b, input int c, input string req);
    int e;
    open_run();
    feed(a, b, c, N);
    e = expect_sum(a, b, c);
    chk(result_valid && res_int() == e, req, res_int(), e);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(result == '0, "R1 result", res_int(), 0);
    chk(!result_valid, "R1 valid", int'(result_valid), 0);

    // R4 R3 R2 exhaustive sweep, back to back
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        for (int c = -8; c < 8; c++)
          full_op(a, b, c, "R4 sweep");

    // R9: strobe falls after one cycle
    @(negedge clk);
    chk(!result_valid, "R9 strobe width", int'(result_valid), 0);

    // R8 extremes
    full_op(-8, -8, -8, "R8 all negative");
    full_op(-8, 7, -8, "R8 max magnitude");
    full_op(7, 7, 7, "R8 all positive");

    // R5: idle bits ignored
    held = res_int();
    for (int i = 0; i < 8; i++) begin
      bits_in = K'(i * 5 + 3);
      @(negedge clk);
      chk(res_int() == held && !result_valid, "R5 idle hold", res_int(), held);
    end
    bits_in = '0;

    // R6: abort mid run
    open_run();
    feed(5, -3, 2, 2);
    chk(!result_valid, "R6 no valid mid run", int'(result_valid), 0);
    full_op(-6, 4, 3, "R6 restart result");

    // R7: start in the sign slot of the old run
    open_run();
    feed(-7, 6, 1, N - 1);
    start = 1'b1;
    bits_in = '1;
    @(negedge clk);
    start = 1'b0;
    bits_in = '0;
    chk(!result_valid, "R7 no valid on collision", int'(result_valid), 0);
    chk(result == '0, "R6 cleared by start", res_int(), 0);
    feed(3, -5, 6, N);
    chk(result_valid && res_int() == expect_sum(3, -5, 6), "R7 new run",
        res_int(), expect_sum(3, -5, 6));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule